// File: doc/BRIEF.md
# Reciprocal Timestamp Phase-Locked Loop

This block is a fixed-point digital phase-locked loop that runs once for each update strobe. Updates are spaced 2^DT2 cycles of a free-running counter apart. An update may carry a wrapping 32-bit timestamp of a reference edge, taken from that counter. From the spacing of these timestamps the loop estimates the update rate relative to the reference. It keeps a frequency term and a phase term, both scaled so that 2^32 is one full turn. A frequency of 2^32 would mean the update rate equals the reference rate.

Each update first advances the phase by the current frequency. When a timestamp is present, the loop measures the period since the previous timestamp. It multiplies that period by the frequency-loop estimate and compares the product with a fixed reference phase to adjust the frequency term. It then corrects the combined frequency using the phase error at the time elapsed since the edge. Two run-time shift settings set the settling times of the frequency loop and the phase loop. The multiply is spread over three clocks. While that work is in flight the block shows busy and drops further strobes. The counter and the edge capture live outside this block.

Top module: `recip_pll`

## Requirements
- R1: After reset, phase_o, freq_o, res_vld_o, busy_o and cfg_err_o are all zero, and the internal previous timestamp and frequency-loop estimate are zero.
- R2: Every accepted strobe (upd_i high while busy_o is low) advances phase_o by the freq_o value from before the strobe, modulo 2^32. This happens at the accepting clock edge, whether or not a timestamp is present.
- R3: An accepted strobe without a usable timestamp leaves freq_o, the frequency-loop estimate and the stored timestamp unchanged. It raises res_vld_o in the cycle after the accepting edge.
- R4: An accepted strobe with a timestamp and legal shifts does the following. It sets dx = ts_i − x and then x = ts_i (mod 2^32). It forms p_sig = ((ff·dx as a 64-bit unsigned product) + 2^(shf−1)) >> shf, truncated to 32 bits. It sets p_ref = 2^(32+DT2−shf), truncated to 32 bits, which is zero when the exponent is 32 or more. It updates ff = ff + p_ref − p_sig (mod 2^32). busy_o is high for the two cycles after the accepting edge, and res_vld_o is high in the third.
- R5: In the same update it sets dt = (−x) AND (2^DT2 − 1) using the new x, and y_ref = ((old f) >> DT2)·dt truncated to 32 bits. It sets dy = (y_ref − y) arithmetically shifted right by (shp − DT2), using the already advanced y. It then sets f = new ff + dy.
- R6: A strobe that arrives while busy_o is high is ignored. It changes neither phase_o nor freq_o and produces no extra res_vld_o pulse.
- R7: An accepted strobe with shf_i < DT2 or shp_i < DT2 sets cfg_err_o. The flag stays high until reset. That strobe only advances the phase, even if it carries a timestamp, and it signals res_vld_o one cycle later.
- R8: res_vld_o is never high while busy_o is high. Exactly one res_vld_o pulse follows each accepted strobe.
- R9: With reference edges at a constant period P plus ±1 count of jitter, shf=12 and shp=11, freq_o settles to within 2% of 2^(32+DT2)/P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_i | input | 1 | Update strobe |
| ts_vld_i | input | 1 | A timestamp comes with this strobe |
| ts_i | input | 32 | Wrapping reference edge timestamp in counter cycles |
| shf_i | input | 6 | Frequency loop shift (settling time 2^shf counter cycles) |
| shp_i | input | 6 | Phase loop shift |
| phase_o | output | 32 | Phase estimate, 2^32 per turn |
| freq_o | output | 32 | Frequency estimate, 2^32 per turn |
| res_vld_o | output | 1 | One-cycle pulse when phase_o and freq_o are final |
| busy_o | output | 1 | A timestamp update is in flight; strobes are dropped |
| cfg_err_o | output | 1 | Sticky illegal-shift flag |

## Verification
The main update path is driven with several kinds of input. Hand-picked timestamps with mid-range shifts separate the rounding and the sign of the product. Shifts equal to DT2, and a frequency shift above 32+DT2, expose errors in the reference-phase exponent and the phase shift. A timestamp pair across the 2^32 wrap checks the modular period. Strobes without timestamps after the frequency has become non-zero separate the phase advance from the frequency path. A long run against a jittered constant-period reference, starting just below the wrap point, shows whether the loop gains and signs lead to the expected frequency. Every result is also compared bit for bit with a model of the update equations.

// File: rtl/recip_pll.sv
module recip_pll #(
  parameter int DT2 = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        upd_i,
  input  logic        ts_vld_i,
  input  logic [31:0] ts_i,
  input  logic [5:0]  shf_i,
  input  logic [5:0]  shp_i,
  output logic [31:0] phase_o,
  output logic [31:0] freq_o,
  output logic        res_vld_o,
  output logic        busy_o,
  output logic        cfg_err_o
);

  localparam int          PW   = 32 + DT2;
  localparam logic [31:0] MASK = 32'((64'd1 << DT2) - 64'd1);
  localparam logic [5:0]  DT2S = 6'(DT2);

  logic [1:0]  stage_q;
  logic [31:0] x_q, ff_q, f_q, y_q, dx_q;
  logic [63:0] prod_q;
  logic [5:0]  shf_q, shp_q;
  logic        vld_q, err_q;

  logic        accept, cfg_bad, take_ts;
  logic [63:0] rbias;
  logic [6:0]  pref_sh;
  logic [31:0] psig, pref, ff_nx, dt, yref;
  logic signed [31:0] perr, dy;

  assign accept  = upd_i && (stage_q == 2'd0);
  assign cfg_bad = (shf_i < DT2S) || (shp_i < DT2S);
  assign take_ts = ts_vld_i && !cfg_bad;

  assign rbias   = 64'd1 << (shf_q - 6'd1);
  assign psig    = 32'((prod_q + rbias) >> shf_q);
  assign pref_sh = 7'(PW) - {1'b0, shf_q};
  assign pref    = 32'(64'd1 << pref_sh);
  assign ff_nx   = ff_q + pref - psig;

  assign dt      = (-x_q) & MASK;
  assign yref    = (f_q >> DT2) * dt;
  assign perr    = yref - y_q;
  assign dy      = perr >>> (shp_q - DT2S);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'd0;
      x_q     <= '0;
      ff_q    <= '0;
      f_q     <= '0;
      y_q     <= '0;
      dx_q    <= '0;
      prod_q  <= '0;
      shf_q   <= '0;
      shp_q   <= '0;
      vld_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      case (stage_q)
        2'd0: if (accept) begin
          y_q <= y_q + f_q;
          if (cfg_bad) err_q <= 1'b1;
          if (take_ts) begin
            dx_q    <= ts_i - x_q;
            x_q     <= ts_i;
            shf_q   <= shf_i;
            shp_q   <= shp_i;
            stage_q <= 2'd1;
          end else begin
            vld_q <= 1'b1;
          end
        end
        2'd1: begin
          prod_q  <= {32'd0, ff_q} * {32'd0, dx_q};
          stage_q <= 2'd2;
        end
        default: begin
          ff_q    <= ff_nx;
          f_q     <= ff_nx + dy;
          vld_q   <= 1'b1;
          stage_q <= 2'd0;
        end
      endcase
    end
  end

  assign phase_o   = y_q;
  assign freq_o    = f_q;
  assign res_vld_o = vld_q;
  assign busy_o    = (stage_q != 2'd0);
  assign cfg_err_o = err_q;

  p_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> phase_o == $past(phase_o + freq_o));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !take_ts) |=> (freq_o == $past(freq_o)) && res_vld_o);

  p_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && take_ts) |=> busy_o ##1 (busy_o && !res_vld_o) ##1 (res_vld_o && !busy_o));

  p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(phase_o));

  p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cfg_bad) |=> cfg_err_o);

  p_err_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |=> cfg_err_o);

  p_vld_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |-> !busy_o);

endmodule

// File: tb/tb_recip_pll.sv
module tb_recip_pll;
  localparam int DT2 = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_i = 1'b0, ts_vld_i = 1'b0;
  logic [31:0] ts_i = '0;
  logic [5:0]  shf_i = '0, shp_i = '0;
  logic [31:0] phase_o, freq_o;
  logic        res_vld_o, busy_o, cfg_err_o;

  always #2 clk = ~clk;

  recip_pll #(.DT2(DT2)) dut (
    .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .ts_vld_i(ts_vld_i), .ts_i(ts_i),
    .shf_i(shf_i), .shp_i(shp_i), .phase_o(phase_o), .freq_o(freq_o),
    .res_vld_o(res_vld_o), .busy_o(busy_o), .cfg_err_o(cfg_err_o)
  );

  int checks = 0, fails = 0;
  logic [31:0] m_x, m_ff, m_f, m_y;
  logic [31:0] qp[$], qf[$];
  string       qt[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model(bit v, logic [31:0] ts, logic [5:0] sf, logic [5:0] sp, string tag);
    logic [31:0] dx, psig, pref, ffn, dt, yref, dy;
    logic [63:0] prod;
    m_y = m_y + m_f;
    if (v && int'(sf) >= DT2 && int'(sp) >= DT2) begin
      dx   = ts - m_x;
      m_x  = ts;
      prod = 64'(m_ff) * 64'(dx);
      psig = 32'((prod + (64'd1 << (int'(sf) - 1))) >> sf);
      pref = (int'(sf) <= 32 + DT2) ? 32'(64'd1 << (32 + DT2 - int'(sf))) : 32'd0;
      ffn  = m_ff + pref - psig;
      dt   = (-m_x) & 32'((1 << DT2) - 1);
      yref = (m_f >> DT2) * dt;
      dy   = 32'($signed(yref - m_y) >>> (int'(sp) - DT2));
      m_f  = ffn + dy;
      m_ff = ffn;
    end
    qp.push_back(m_y);
    qf.push_back(m_f);
    qt.push_back(tag);
  endtask

  task automatic upd(bit v, logic [31:0] ts, logic [5:0] sf, logic [5:0] sp, string tag,
                     bit extra = 1'b0);
    model(v, ts, sf, sp, tag);
    upd_i = 1'b1; ts_vld_i = v; ts_i = ts; shf_i = sf; shp_i = sp;
    @(negedge clk);
    if (extra) @(negedge clk);
    upd_i = 1'b0; ts_vld_i = 1'b0;
    while (busy_o) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; upd_i = 1'b0; ts_vld_i = 1'b0;
    repeat (3) @(negedge clk);
    m_x = '0; m_ff = '0; m_f = '0; m_y = '0;
    qp.delete(); qf.delete(); qt.delete();
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && res_vld_o) begin
      if (qp.size() == 0) begin
        checks++; fails++;
        $display("FAIL R8 unexpected result: got %h expected none", phase_o);
      end else begin
        string t;
        t = qt.pop_front();
        chk({t, " phase"}, phase_o, qp.pop_front());
        chk({t, " freq"}, freq_o, qf.pop_front());
      end
    end
  end

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    longint edge_t, sum, avg, diff, tgt;
    int     k;
    do_reset();
    chk("R1 phase", phase_o, 0);
    chk("R1 freq", freq_o, 0);
    chk("R1 flags", {29'd0, res_vld_o, busy_o, cfg_err_o}, 0);

    upd(0, 0, 12, 11, "R2 R3 idle");
    upd(0, 0, 12, 11, "R2 R3 idle");
    upd(1, 32'd100, 12, 11, "R4 R5 first ts");
    upd(1, 32'd205, 12, 11, "R4 R5 second ts");
    upd(1, 32'd311, 12, 11, "R5");
    upd(0, 0, 12, 11, "R2 advance");
    upd(0, 0, 12, 11, "R3 hold");
    upd(1, 32'd420, 4, 4, "R4 shift at dt2");
    upd(1, 32'd530, 40, 20, "R4 large shift");
    upd(1, 32'hFFFF_FFF0, 12, 11, "R4 near wrap");
    upd(1, 32'h0000_0050, 12, 11, "R4 across wrap");
    upd(0, 0, 12, 11, "R2 advance");

    upd(1, 32'd650, 12, 11, "R6 drop", 1'b1);
    repeat (4) @(negedge clk);
    chk("R6 no extra result", qp.size(), 0);
    chk("R6 phase", phase_o, m_y);
    chk("R6 freq", freq_o, m_f);

    chk("R7 flag clear", {31'd0, cfg_err_o}, 0);
    upd(1, 32'd800, 3, 11, "R7 bad shf");
    chk("R7 flag set", {31'd0, cfg_err_o}, 1);
    upd(1, 32'd900, 12, 11, "R7 ts kept");
    upd(0, 0, 12, 2, "R7 bad shp");
    chk("R7 flag sticky", {31'd0, cfg_err_o}, 1);
    upd(1, 32'd1010, 12, 11, "R7 after err");
    @(negedge clk);

    do_reset();
    k = 0;
    edge_t = 37;
    sum = 0;
    for (int n = 1; n <= 12000; n++) begin
      longint now;
      now = longint'(n) * 16;
      if (edge_t <= now) begin
        upd(1, 32'(64'hFFFF_F000 + edge_t), 12, 11, "R9 track");
        k++;
        edge_t = longint'(k) * 100 + longint'(k % 3) - 1 + 37;
      end else begin
        upd(0, 0, 12, 11, "R9 track");
      end
      if (n > 12000 - 64) sum += longint'(freq_o);
    end
    avg  = sum / 64;
    tgt  = (longint'(1) << (32 + DT2)) / 100;
    diff = (avg > tgt) ? avg - tgt : tgt - avg;
    checks++;
    if (diff * 50 > tgt) begin
      fails++;
      $display("FAIL R9 convergence: got %0d expected %0d", avg, tgt);
    end
    repeat (4) @(negedge clk);
    chk("R8 queue drained", qp.size(), 0);
    summary();
  end
endmodule